// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for each received Ethernet frame, whether the frame should be handed to the host. It watches a byte-wide receive stream and collects the six destination address bytes as they arrive. While collecting them it computes a running CRC-32 over those bytes. One cycle after the sixth address byte it raises a single-cycle decision strobe. The strobe carries a forward/drop verdict and a flag that marks the address as the reserved PAUSE control address.

Eight static configuration bits select the filtering policy. Unicast and multicast addresses can each be checked either against a set of exact-match address slots or against a hash table indexed by six bits of the CRC. The match result can be inverted. Broadcast, pass-all-multicast, promiscuous and receive-everything overrides can replace it. The MAC receive path upstream and the frame CRC check are not part of the block, and neither is the pause timer that acts on the flag.

Top module: `dafilt_top`

## Requirements
- R1: A byte is taken when `rx_valid` is 1. `rx_sof` together with `rx_valid` marks destination byte 0 and restarts collection at any time. Without `rx_sof`, bytes 1 to 5 are taken in order. `dec_valid` is 1 for exactly one cycle, on the cycle after the byte-5 edge. Bytes after byte 5 produce no further strobe until the next `rx_sof`.
- R2: With `ctrl[0]` (receive everything) set, every frame is forwarded, PAUSE frames included.
- R3: The address whose bytes arrive as 01, 80, C2, 00, 00, 01 raises `dec_pause`. Such a frame is forwarded only when `ctrl[7]` (pass PAUSE) or `ctrl[0]` is set.
- R4: With `ctrl[1]` (promiscuous) set, every frame other than PAUSE is forwarded.
- R5: A destination of all ones (broadcast) is rejected when `ctrl[2]` is set and forwarded when it is clear, unless R2 or R4 applies.
- R6: A frame whose first received byte has bit 0 set (multicast) is forwarded when `ctrl[3]` is set, whatever the hash and inverse settings.
- R7: For a unicast frame, `ctrl[5]` clear selects exact matching against the slots whose `slot_en` bit is 1. Slot k holds destination byte j in `slot_addr[48*k+8*j +: 8]`. `ctrl[5]` set selects the hash table.
- R8: For a multicast frame that is neither broadcast nor PAUSE, `ctrl[6]` selects the hash table when set and exact slot matching when clear.
- R9: The hash index is bits [31:26] of a CRC register. The register starts at all ones. Each address byte is shifted in least significant bit first using the reflected polynomial 0xEDB88320, and no final inversion is applied. The frame matches when `hash_tbl` has a 1 at that index.
- R10: `ctrl[4]` (inverse) inverts the result of the R7/R8 match step only.
- R11: `dec_fwd` and `dec_pause` are 0 whenever `dec_valid` is 0, and reset clears `dec_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Receive byte strobe |
| rx_sof | input | 1 | First byte of frame marker |
| rx_data | input | 8 | Receive byte |
| ctrl | input | 8 | Filter policy bits (see R2 to R10) |
| slot_addr | input | 48*NUM_SLOTS | Exact-match addresses, byte 0 in low bits |
| slot_en | input | NUM_SLOTS | Enable per exact-match slot |
| hash_tbl | input | 2**HASH_BITS | Hash match table |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_fwd | output | 1 | Forward verdict |
| dec_pause | output | 1 | PAUSE address seen |

## Verification
The assertions assume that `ctrl`, `slot_addr`, `slot_en` and `hash_tbl` are static across the cycle of each decision strobe. The verdict reads them combinationally at that moment. The bench changes them only while the receive side is idle, between frames. The assertions also assume that `rx_sof` is only meaningful when `rx_valid` is high, so the stimulus never raises it alone. The sweep covers all 256 control values against unicast, multicast, broadcast and PAUSE addresses, with two hash tables and two slot-enable patterns. It also inserts idle gaps and trailing bytes and restarts a frame part-way through.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

   localparam int ADDR_BYTES = 6;
   localparam int ADDR_W     = 8 * ADDR_BYTES;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
   // Reserved PAUSE destination, first received byte in the low bits
   localparam logic [ADDR_W-1:0] PAUSE_DA = 48'h0100_00C2_8001;

   typedef struct packed {
      logic pause_pass;   // bit 7
      logic mcast_hash;   // bit 6
      logic ucast_hash;   // bit 5
      logic inverse;      // bit 4
      logic mcast_all;    // bit 3
      logic bcast_block;  // bit 2
      logic promisc;      // bit 1
      logic recv_all;     // bit 0
   } filt_ctrl_t;

   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      logic        fb;
      r = c;
      for (int i = 0; i < 8; i++) begin
         fb = r[0] ^ d[i];
         r  = {1'b0, r[31:1]};
         if (fb) r = r ^ CRC_POLY_REFL;
      end
      return r;
   endfunction

endpackage

// File: rtl/dafilt_collect.sv
module dafilt_collect
   import dafilt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic [7:0]        rx_data,
   output logic [ADDR_W-1:0] da,
   output logic [31:0]       crc,
   output logic              done
);
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] idx;
   logic             take;
   logic [7:0]       byte_q [ADDR_BYTES];

   assign idx  = rx_sof ? '0 : cnt_q;
   assign take = rx_valid && (rx_sof || (cnt_q < IDLE_CNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= IDLE_CNT;
         crc   <= CRC_SEED;
         done  <= 1'b0;
         for (int b = 0; b < ADDR_BYTES; b++) byte_q[b] <= '0;
      end else begin
         done <= take && (idx == LAST_IDX);
         if (take) begin
            cnt_q <= idx + 1'b1;
            crc   <= crc_step((idx == '0) ? CRC_SEED : crc, rx_data);
            for (int b = 0; b < ADDR_BYTES; b++)
               if (idx == CNT_W'(b)) byte_q[b] <= rx_data;
         end
      end
   end

   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_pack
      assign da[8*g +: 8] = byte_q[g];
   end

endmodule

// File: rtl/dafilt_match.sv
module dafilt_match
   import dafilt_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   parameter int HASH_BITS = 6,
   localparam int TBL_W = 1 << HASH_BITS
)(
   input  logic [ADDR_W-1:0]           da,
   input  logic [HASH_BITS-1:0]        hash_idx,
   input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr,
   input  logic [NUM_SLOTS-1:0]        slot_en,
   input  logic [TBL_W-1:0]            hash_tbl,
   output logic                        perfect_hit,
   output logic                        hash_hit
);
   logic [NUM_SLOTS-1:0] slot_hit;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign slot_hit[s] = slot_en[s] && (slot_addr[s*ADDR_W +: ADDR_W] == da);
   end

   assign perfect_hit = |slot_hit;
   assign hash_hit    = hash_tbl[hash_idx];

endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
   import dafilt_pkg::*;
(
   input  filt_ctrl_t cfg,
   input  logic       is_pause,
   input  logic       is_bcast,
   input  logic       is_mcast,
   input  logic       perfect_hit,
   input  logic       hash_hit,
   output logic       fwd
);
   logic use_hash;
   logic raw_hit;

   always_comb begin
      use_hash = is_mcast ? cfg.mcast_hash : cfg.ucast_hash;
      raw_hit  = use_hash ? hash_hit : perfect_hit;
      if (cfg.recv_all)                  fwd = 1'b1;
      else if (is_pause)                 fwd = cfg.pause_pass;
      else if (cfg.promisc)              fwd = 1'b1;
      else if (is_bcast)                 fwd = !cfg.bcast_block;
      else if (is_mcast && cfg.mcast_all) fwd = 1'b1;
      else                               fwd = raw_hit ^ cfg.inverse;
   end

endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
   import dafilt_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   parameter int HASH_BITS = 6
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rx_valid,
   input  logic                          rx_sof,
   input  logic [7:0]                    rx_data,
   input  logic [7:0]                    ctrl,
   input  logic [NUM_SLOTS*48-1:0]       slot_addr,
   input  logic [NUM_SLOTS-1:0]          slot_en,
   input  logic [(1 << HASH_BITS)-1:0]   hash_tbl,
   output logic                          dec_valid,
   output logic                          dec_fwd,
   output logic                          dec_pause
);
   localparam int TBL_W = 1 << HASH_BITS;

   if (NUM_SLOTS < 1 || NUM_SLOTS > 64) begin : g_bad_slots
      $error("dafilt_top: NUM_SLOTS out of range");
   end
   if (HASH_BITS < 1 || HASH_BITS > 8) begin : g_bad_hash
      $error("dafilt_top: HASH_BITS out of range");
   end

   logic [ADDR_W-1:0] da;
   logic [31:0]       crc;
   logic              done;
   logic              perfect_hit, hash_hit, fwd_raw;
   logic              is_pause, is_bcast, is_mcast;

   dafilt_collect u_collect (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_sof   (rx_sof),
      .rx_data  (rx_data),
      .da       (da),
      .crc      (crc),
      .done     (done)
   );

   dafilt_match #(.NUM_SLOTS(NUM_SLOTS), .HASH_BITS(HASH_BITS)) u_match (
      .da          (da),
      .hash_idx    (crc[31 -: HASH_BITS]),
      .slot_addr   (slot_addr),
      .slot_en     (slot_en),
      .hash_tbl    (hash_tbl[TBL_W-1:0]),
      .perfect_hit (perfect_hit),
      .hash_hit    (hash_hit)
   );

   assign is_pause = (da == PAUSE_DA);
   assign is_bcast = &da;
   assign is_mcast = da[0];

   dafilt_decide u_decide (
      .cfg         (filt_ctrl_t'(ctrl)),
      .is_pause    (is_pause),
      .is_bcast    (is_bcast),
      .is_mcast    (is_mcast),
      .perfect_hit (perfect_hit),
      .hash_hit    (hash_hit),
      .fwd         (fwd_raw)
   );

   assign dec_valid = done;
   assign dec_fwd   = done & fwd_raw;
   assign dec_pause = done & is_pause;

endmodule

// File: rtl/dafilt_checker.sv
module dafilt_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic [7:0] ctrl,
   input logic       dec_valid,
   input logic       dec_fwd,
   input logic       dec_pause
);
   p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   p_pulse_after_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(rx_valid));

   p_recv_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && ctrl[0]) |-> dec_fwd);

   p_pause_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_pause && !ctrl[0] && !ctrl[7]) |-> !dec_fwd);

   p_promisc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && ctrl[1] && !dec_pause) |-> dec_fwd);

   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (!dec_fwd && !dec_pause));
endmodule

bind dafilt_top dafilt_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .ctrl      (ctrl),
   .dec_valid (dec_valid),
   .dec_fwd   (dec_fwd),
   .dec_pause (dec_pause)
);

// File: tb/tb_dafilt_top.sv
module tb_dafilt_top;
   localparam int NS = 2;
   localparam int HB = 6;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          rx_valid = 0, rx_sof = 0;
   logic [7:0]    rx_data = 0;
   logic [7:0]    ctrl = 0;
   logic [NS*48-1:0] slot_addr = 0;
   logic [NS-1:0] slot_en = 0;
   logic [63:0]   hash_tbl = 0;
   logic          dec_valid, dec_fwd, dec_pause;

   int checks = 0, failures = 0;
   bit done_flag = 0;

   always #5 clk = ~clk;

   dafilt_top #(.NUM_SLOTS(NS), .HASH_BITS(HB)) dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_data(rx_data), .ctrl(ctrl), .slot_addr(slot_addr), .slot_en(slot_en),
      .hash_tbl(hash_tbl), .dec_valid(dec_valid), .dec_fwd(dec_fwd),
      .dec_pause(dec_pause)
   );

   localparam logic [47:0] A_U0  = 48'h5544_3322_1100;
   localparam logic [47:0] A_U1  = 48'h0F0E_0D0C_0B0A;
   localparam logic [47:0] A_M1  = 48'h6655_4433_2201;
   localparam logic [47:0] A_M2  = 48'hBBAA_9988_7733;
   localparam logic [47:0] A_BC  = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] A_PS  = 48'h0100_00C2_8001;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // R9 hash index, written byte-at-a-time
   function automatic int hidx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int k = 0; k < 6; k++) begin
         c = c ^ {24'h0, a[8*k +: 8]};
         for (int j = 0; j < 8; j++)
            c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      return int'(c[31:26]);
   endfunction

   task automatic model(input logic [7:0] c, input logic [47:0] a,
                        output bit f, output bit p, output string tag);
      bit mc, hit, useh;
      p = (a == A_PS);
      mc = a[0];
      f = 0;
      if (c[0])                 begin f = 1; tag = "R2"; end
      else if (p)               begin f = c[7]; tag = "R3"; end
      else if (c[1])            begin f = 1; tag = "R4"; end
      else if (&a)              begin f = !c[2]; tag = "R5"; end
      else if (mc && c[3])      begin f = 1; tag = "R6"; end
      else begin
         useh = mc ? c[6] : c[5];
         if (useh) hit = hash_tbl[hidx(a)];
         else begin
            hit = 0;
            for (int s = 0; s < NS; s++)
               if (slot_en[s] && slot_addr[48*s +: 48] == a) hit = 1;
         end
         f = hit ^ c[4];
         tag = mc ? (useh ? "R8 R9 R10" : "R8 R10") : (useh ? "R7 R9 R10" : "R7 R10");
      end
   endtask

   task automatic put(input logic s, input logic [7:0] d);
      @(negedge clk); rx_sof = s; rx_valid = 1; rx_data = d;
   endtask
   task automatic idle;
      @(negedge clk); rx_sof = 0; rx_valid = 0; rx_data = 0;
   endtask

   task automatic frame(input logic [47:0] a, input bit gap, input bit trail);
      bit ef, ep; string tag;
      put(1, a[7:0]);
      for (int k = 1; k < 6; k++) begin
         if (gap && k == 3) begin
            idle();
            chk(dec_valid == 0, "R1", "no strobe during gap", dec_valid, 0);
         end
         put(0, a[8*k +: 8]);
      end
      idle();
      model(ctrl, a, ef, ep, tag);
      chk(dec_valid == 1, "R1", "strobe after byte 5", dec_valid, 1);
      chk(dec_fwd == ef, tag, $sformatf("fwd ctrl=%02h da=%012h", ctrl, a), dec_fwd, ef);
      chk(dec_pause == ep, "R3", "pause flag", dec_pause, ep);
      if (trail) begin
         put(0, 8'hFF);
         chk(dec_valid == 0 && dec_fwd == 0, "R11", "strobe one cycle", dec_valid, 0);
         put(0, 8'h01);
         idle();
         chk(dec_valid == 0, "R1", "trailing bytes ignored", dec_valid, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [47:0] addrs [6];
      addrs[0] = A_U0; addrs[1] = A_U1; addrs[2] = A_M1;
      addrs[3] = A_M2; addrs[4] = A_BC; addrs[5] = A_PS;
      slot_addr = {A_M1, A_U0};
      slot_en = 2'b11;
      repeat (3) @(negedge clk);
      chk(dec_valid == 0 && dec_fwd == 0 && dec_pause == 0, "R11", "reset state",
          {dec_valid, dec_fwd, dec_pause}, 0);
      rst_n = 1;
      idle();
      chk(dec_valid == 0, "R11", "idle after reset", dec_valid, 0);

      // restart mid-frame: partial bytes then a fresh frame
      ctrl = 8'h00;
      put(1, 8'h00); put(0, 8'h11); put(0, 8'h22);
      frame(A_U1, 0, 0);
      chk(1, "R1", "restart accounted", 0, 0);
      put(1, 8'h0A); put(0, 8'h0B);
      frame(A_U0, 0, 1);

      for (int t = 0; t < 2; t++) begin
         hash_tbl = (t == 0) ? 64'hA5C3_0F96_3C5A_F00F : ~64'hA5C3_0F96_3C5A_F00F;
         for (int e = 0; e < 2; e++) begin
            slot_en = (e == 0) ? 2'b11 : 2'b10;
            for (int c = 0; c < 256; c++) begin
               ctrl = 8'(c);
               for (int i = 0; i < 6; i++)
                  frame(addrs[i], ((c + i) % 3) == 0, ((c + i) % 4) == 0);
            end
         end
      end

      idle();
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule